// File: doc/BRIEF.md
# Masked Interrupt Register Block

This block is the interrupt front end of a peripheral. Eight event lines come in from the peripheral core. A rising edge on any line sets the matching bit of a sticky status register. Software clears status bits by writing a mask. A per-source enable register and one global gate bit decide whether a pending event raises the single interrupt request line.

The same small register window also holds a keyed reset register. Writing the exact key value produces a one-cycle reset pulse toward the peripheral core. The same write returns the status register, the enable register and the global gate to zero. Any other value written there is ignored.

Access is through a plain 32-bit port: a byte offset, a write strobe with write data, and combinational read data.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is 0 and `core_rst` is 0.
- R2: A 0-to-1 transition of `events[i]`, sampled at a clock edge, sets status bit i (offset 0x20, bit i) at that edge. A line held high does not set the bit again after it has been cleared.
- R3: Writing a word to offset 0x20 clears each status bit whose mask bit is 1 and leaves bits with mask bit 0 unchanged.
- R4: If a status bit is cleared by a write and set by a rising event in the same cycle, it ends up set.
- R5: The enable register at offset 0x28 stores bits [7:0] of the write data and reads them back unchanged, with bits [31:8] reading zero.
- R6: The global gate is bit 31 of offset 0x1C. A write stores only bit 31, and a read returns bit 31 with all other bits zero.
- R7: `irq` is 1 exactly when the global gate is 1 and the bitwise AND of status and enable is nonzero.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `core_rst` high for one cycle, starting after the write edge. The same edge clears status, enable and the global gate, and this clear wins over an event edge in that cycle.
- R9: Writing any other value to offset 0x40 leaves `core_rst` low and all registers unchanged. Offset 0x40 reads zero.
- R10: Reads from offsets other than 0x1C, 0x20 and 0x28 return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| events | input | 8 | Event lines from the peripheral core, edge sensitive |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| core_rst | output | 1 | One-cycle reset pulse to the peripheral core |

## Verification
The assertions are checked on every cycle. They cover these properties:
- An event edge always lands in status.
- A clear write removes exactly the masked bits that are not rising.
- No status bit appears without an edge.
- An enable write reads back its value.
- The request stays low while the gate is off.
- Every reset pulse leaves status, enable and the gate at zero.

Only the bench scenarios can show the full request function over all 256 status patterns with both gate settings. They also cover the set-over-clear collision, a line held high that must not re-set its bit, rejected reset keys, and unmapped offsets.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared widths, register offsets and the register-select type
// for the masked interrupt register block.
package irq_ctrl_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_SRC  = 8;
    localparam int GATE_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFF_GATE   = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] OFF_ENABLE = ADDR_W'(8'h28);
    localparam logic [ADDR_W-1:0] OFF_KEYRST = ADDR_W'(8'h40);

    localparam logic [DATA_W-1:0] RESET_KEY = DATA_W'(32'h0000_000A);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GATE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_KEYRST
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Maps a byte offset onto one of the block's registers.
// Assumes offsets are compared exactly; no aliasing of unused address bits.
module irq_addr_decode
    import irq_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Purpose: exact-match decode of the four mapped offsets.
    always_comb begin
        unique case (addr)
            OFF_GATE:   sel = SEL_GATE;
            OFF_STATUS: sel = SEL_STATUS;
            OFF_ENABLE: sel = SEL_ENABLE;
            OFF_KEYRST: sel = SEL_KEYRST;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_event_latch.sv
// Module: irq_event_latch
// Edge-detects each event line and holds a sticky status bit per line.
// Bits are cleared by a mask write, and a rising edge in the same cycle wins.
// A global clear (keyed reset) beats both.
// Assumes the event lines are synchronous to clk.
module irq_event_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         clr_all,
    output logic [N-1:0] status
);
    logic [N-1:0] ev_prev;
    logic [N-1:0] rise;

    // Purpose: remember last sampled level of each event line.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_prev <= '0;
        else        ev_prev <= events;
    end

    assign rise = events & ~ev_prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: sticky status bit with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)           status[i] <= 1'b0;
            else if (rise[i])                status[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])  status[i] <= 1'b0;
        end
    end

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise != '0) && !clr_all) |=> ((status & $past(rise)) == $past(rise)));
    // R3
    clear_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !clr_all) |=> ((status & $past(clr_mask & ~rise)) == '0));
    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_enable_regs.sv
// Module: irq_enable_regs
// Holds the per-source enable mask and the global gate bit.
// Both load on a write to their own offset and are cleared by the keyed reset.
module irq_enable_regs #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic         gate_wr,
    input  logic         gate_wdata,
    input  logic         clr_all,
    output logic [N-1:0] enable,
    output logic         gate
);
    // Purpose: per-source enable register, stored exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) enable <= '0;
        else if (en_wr)        enable <= en_wdata;
    end

    // Purpose: single global gate bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) gate <= 1'b0;
        else if (gate_wr)      gate <= gate_wdata;
    end

    // R5
    enable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !clr_all) |=> (enable == $past(en_wdata)));
    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_wr && !clr_all) |=> $stable(gate));
endmodule

// File: rtl/irq_sw_reset.sv
// Module: irq_sw_reset
// Compares a write to the reset offset against the key.
// On a match it emits a one-cycle registered pulse.
// Assumes the key is compared over the full data word.
module irq_sw_reset
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    output logic              key_hit,
    output logic              pulse
);
    assign key_hit = key_wr && (key_wdata == RESET_KEY);

    // Purpose: register the key match into the outgoing reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= key_hit;
    end

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(key_hit));
    // R9
    bad_key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && (key_wdata != RESET_KEY)) |=> !pulse);
endmodule

// File: rtl/irq_ctrl_unit.sv
// Module: irq_ctrl_unit (top)
// Interrupt register window with these parts:
//   - sticky event status with write-1-to-clear,
//   - per-source enable and a global gate,
//   - a keyed one-cycle core reset.
// Reads are combinational. Assumes one access per cycle.
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] events,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq,
    output logic               core_rst
);
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic               gate;
    logic               key_hit;

    irq_addr_decode u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    irq_sw_reset u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (reg_wr && (sel == SEL_KEYRST)),
        .key_wdata (reg_wdata),
        .key_hit   (key_hit),
        .pulse     (core_rst)
    );

    irq_event_latch #(.N(NUM_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .clr_wr   (reg_wr && (sel == SEL_STATUS)),
        .clr_mask (reg_wdata[NUM_SRC-1:0]),
        .clr_all  (key_hit),
        .status   (status)
    );

    irq_enable_regs #(.N(NUM_SRC)) u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (reg_wr && (sel == SEL_ENABLE)),
        .en_wdata   (reg_wdata[NUM_SRC-1:0]),
        .gate_wr    (reg_wr && (sel == SEL_GATE)),
        .gate_wdata (reg_wdata[GATE_BIT]),
        .clr_all    (key_hit),
        .enable     (enable),
        .gate       (gate)
    );

    // Purpose: request when gated on and any enabled source is pending.
    always_comb irq = gate && ((status & enable) != '0);

    // Purpose: read-data multiplexer over the mapped registers.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_GATE:   reg_rdata[GATE_BIT] = gate;
            SEL_STATUS: reg_rdata[NUM_SRC-1:0] = status;
            SEL_ENABLE: reg_rdata[NUM_SRC-1:0] = enable;
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !irq);
    // R8
    key_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (status == '0 && enable == '0 && !gate));
endmodule

// File: tb/test_irq_ctrl_unit.sv
module test_irq_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  events = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        core_rst;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_ctrl_unit i_irq_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .events(events), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .core_rst(core_rst)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // write: drive at negedge, captured at posedge, released at next negedge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one-cycle event pulse: high across exactly one posedge
    task automatic pulse_ev(logic [7:0] p);
        @(negedge clk);
        events = p;
        @(negedge clk);
        events = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h1C, d); chk("R1 gate", d, 0);
        rd(8'h20, d); chk("R1 status", d, 0);
        rd(8'h28, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 core_rst", {31'b0, core_rst}, 0);

        // R5 exhaustive enable readback
        for (int v = 0; v < 256; v++) begin
            wr(8'h28, {24'hA5A5A5, 8'(v)});
            rd(8'h28, d); chk("R5 enable readback", d, 32'(v));
        end

        // R6 gate bit only
        wr(8'h1C, 32'h7FFF_FFFF); rd(8'h1C, d); chk("R6 gate low bits ignored", d, 0);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R6 gate set", d, 32'h8000_0000);
        wr(8'h1C, 32'h0);

        // R2 R3 R7 sweep over all status patterns, both gate settings
        for (int s = 0; s < 256; s++) begin
            e = 8'((s * 37 + 11) & 255);
            wr(8'h28, {24'b0, e});
            pulse_ev(8'(s));
            rd(8'h20, d); chk("R2 status after edges", d, 32'(s));
            chk("R7 irq gate off", {31'b0, irq}, 0);
            wr(8'h1C, 32'h8000_0000);
            rd(8'h20, d);
            chk("R7 irq gate on", {31'b0, irq}, {31'b0, ((8'(s) & e) != 0)});
            wr(8'h20, 32'h0000_00FF);
            rd(8'h20, d); chk("R3 full clear", d, 0);
            chk("R7 irq after clear", {31'b0, irq}, 0);
            wr(8'h1C, 32'h0);
        end

        // R3 partial clear
        pulse_ev(8'hFF);
        wr(8'h20, 32'h0000_005A);
        rd(8'h20, d); chk("R3 partial clear", d, 32'h0000_00A5);
        wr(8'h20, 32'hFF);

        // R2 held-high line does not re-set after clear
        @(negedge clk); events = 8'h01;
        @(negedge clk);
        rd(8'h20, d); chk("R2 held line set", d, 32'h01);
        wr(8'h20, 32'h01);
        @(negedge clk);
        rd(8'h20, d); chk("R2 held line no reset", d, 0);
        events = 8'h00;
        @(negedge clk);

        // R4 set wins over clear in same cycle
        pulse_ev(8'h81);
        @(negedge clk);
        reg_addr = 8'h20; reg_wdata = 32'hFF; reg_wr = 1'b1; events = 8'h08;
        @(negedge clk);
        reg_wr = 1'b0; events = 8'h00;
        rd(8'h20, d); chk("R4 set beats clear", d, 32'h08);

        // R9 wrong keys: state unchanged, no pulse
        wr(8'h28, 32'h3C); wr(8'h1C, 32'h8000_0000);
        foreach (d[i]) begin end
        wr(8'h40, 32'h0000_000B); chk("R9 no pulse 0xB", {31'b0, core_rst}, 0);
        wr(8'h40, 32'h0000_001A); chk("R9 no pulse 0x1A", {31'b0, core_rst}, 0);
        wr(8'h40, 32'hA000_000A); chk("R9 no pulse high bits", {31'b0, core_rst}, 0);
        rd(8'h40, d); chk("R9 key reads zero", d, 0);
        rd(8'h20, d); chk("R9 status kept", d, 32'h08);
        rd(8'h28, d); chk("R9 enable kept", d, 32'h3C);
        rd(8'h1C, d); chk("R9 gate kept", d, 32'h8000_0000);
        chk("R7 irq pending", {31'b0, irq}, 1);

        // R10 unmapped offsets
        wr(8'h24, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h24, d); chk("R10 unmapped read", d, 0);
        rd(8'h00, d); chk("R10 unmapped read 0", d, 0);
        rd(8'h28, d); chk("R10 enable untouched", d, 32'h3C);
        rd(8'h20, d); chk("R10 status untouched", d, 32'h08);

        // R8 valid key with an event edge in the same cycle
        @(negedge clk);
        reg_addr = 8'h40; reg_wdata = 32'h0000_000A; reg_wr = 1'b1; events = 8'h10;
        @(negedge clk);
        reg_wr = 1'b0; events = 8'h00;
        chk("R8 pulse high", {31'b0, core_rst}, 1);
        rd(8'h20, d); chk("R8 status cleared", d, 0);
        rd(8'h28, d); chk("R8 enable cleared", d, 0);
        rd(8'h1C, d); chk("R8 gate cleared", d, 0);
        chk("R8 irq low", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, core_rst}, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule